// File: doc/BRIEF.md
# Auto-Ranging Output Gain and Saturation

This block is the output stage of a wide filter datapath. It takes a 32-bit signed accumulated result and reduces it to a 16-bit signed sample. A 20-bit window is first cut from the result. There are four candidate windows, spaced four bits apart starting at the top of the word. The window is picked either by a manual code or by a tracker that learns the needed range from the sign bits of the incoming results. The window is multiplied by a 4-bit unsigned gain. The middle of the product becomes the output, and any product that does not fit raises an overflow flag.

One of two clamping modes may then be applied. The first suits display output: it blacks out negatives and pins overloads at peak white. The second clamps overloads at either rail and leaves everything else untouched. The final sample is compared against a programmed threshold to give a one-bit result.

The range tracker is sticky. After reset, or after any register write (signalled by a strobe), it returns to the least significant window. It then ignores the data for ten line-sync rising edges, so that stale results can drain from the upstream pipeline. From then on it only ever widens toward more significant windows. Its choice is always visible on a 2-bit indicator, whether or not it drives the datapath.

Top module: `gain_sat_out`

## Requirements
- R1: Field code k selects acc bits (31-4k) down to (12-4k): code 0 gives 31:12, 1 gives 27:8, 2 gives 23:4, 3 gives 19:0. With auto_en_i low the code is man_sel_i.
- R2: The selected 20-bit field, read as signed, is multiplied by gain_i read as unsigned, giving a 24-bit product. data_o carries product bits 19:4 when no clamping applies.
- R3: ovf_o is high exactly when product bits 23:19 are not all equal.
- R4: sat_mode_i = 1 (display): a negative product gives data_o = 0x0000, and a positive overflow gives 0x7FFF, so data_o bit 15 is always 0.
- R5: sat_mode_i = 2 (symmetric): a positive overflow gives 0x7FFF and a negative overflow gives 0x8000. Results without overflow, negative ones included, pass unchanged.
- R6: sat_mode_i = 0 or 3: no clamping; data_o is product bits 19:4 even on overflow.
- R7: gt_o is high exactly when data_o, read as signed, is strictly greater than thr_i read as signed. The comparison uses the clamped value.
- R8: The tracker candidate is code 3 if acc bits 31:19 are all equal, else code 2 if bits 31:23 are all equal, else code 1 if bits 31:27 are all equal, else code 0.
- R9: After reset or a cycle with upd_i high, field_o is 3 and stays unchanged until ten rising edges of hres_i have been seen.
- R10: Once armed, field_o takes the candidate only when the candidate is a smaller code. It never moves toward a larger code until the next upd_i.
- R11: field_o always shows the tracker state. With auto_en_i high, that state, not man_sel_i, drives the window selection.
- R12: data_o, ovf_o and gt_o are registered one clock after their inputs. They reset to 0 and field_o resets to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 32 | Signed accumulated result |
| hres_i | input | 1 | Line sync; rising edges count toward the hold-off |
| upd_i | input | 1 | Register-update strobe; restarts the tracker |
| auto_en_i | input | 1 | Use the tracker's field instead of man_sel_i |
| man_sel_i | input | 2 | Manual field code |
| gain_i | input | 4 | Unsigned gain |
| sat_mode_i | input | 2 | 0 none, 1 display, 2 symmetric, 3 none |
| thr_i | input | 16 | Signed compare threshold |
| data_o | output | 16 | Scaled, clamped sample |
| ovf_o | output | 1 | Gain overflow flag |
| gt_o | output | 1 | Sample greater than threshold |
| field_o | output | 2 | Tracker field code |

## Verification
The bench builds the block with its default parameters: a 32-bit input, 20-bit windows at 4-bit steps, a 4-bit gain, a 16-bit output and a ten-line hold-off. These defaults make every window and every clamp reachable with hand-checkable constants. A gain of 4 on a large field is enough to force both positive and negative overflow. Because the hold-off is short, the bench can count it out edge by edge, confirm that nothing moves on the ninth edge, and then walk the tracker through codes 3, 2 and 1 to show it refuses to narrow again.

// File: rtl/gso_pkg.sv
package gso_pkg;
  typedef enum logic [1:0] {
    SAT_NONE    = 2'd0,
    SAT_DISPLAY = 2'd1,
    SAT_SYM     = 2'd2,
    SAT_RSVD    = 2'd3
  } sat_mode_e;
endpackage

// File: rtl/gso_field_track.sv
module gso_field_track #(
  parameter int ACC_W       = 32,
  parameter int FIELD_W     = 20,
  parameter int FIELD_STEP  = 4,
  parameter int NUM_FIELDS  = 4,
  parameter int FLUSH_LINES = 10,
  localparam int SEL_W      = $clog2(NUM_FIELDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             hres_i,
  input  logic             upd_i,
  output logic [SEL_W-1:0] field_o
);
  localparam int CNT_W = $clog2(FLUSH_LINES + 1);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_FIELDS - 1);
  localparam logic [CNT_W-1:0] FLUSH = CNT_W'(FLUSH_LINES);

  logic [NUM_FIELDS-1:0] fits;
  logic [SEL_W-1:0]      cand;
  logic [SEL_W-1:0]      field_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  hres_q;
  logic                  hres_rise;

  assign fits[0] = 1'b1;
  // field k fits when the top k*STEP+1 bits are all copies of the sign
  for (genvar k = 1; k < NUM_FIELDS; k++) begin : g_fit
    localparam int GW = k * FIELD_STEP + 1;
    logic [GW-1:0] grp;
    assign grp     = acc_i[ACC_W-1 -: GW];
    assign fits[k] = (&grp) | ~(|grp);
  end

  always_comb begin
    cand = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (fits[k]) cand = SEL_W'(k);
    end
  end

  assign hres_rise = hres_i & ~hres_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= LAST;
      cnt_q   <= FLUSH;
      hres_q  <= 1'b0;
    end else begin
      hres_q <= hres_i;
      if (upd_i) begin
        field_q <= LAST;
        cnt_q   <= FLUSH;
      end else if (cnt_q != '0) begin
        if (hres_rise) cnt_q <= cnt_q - 1'b1;
      end else if (cand < field_q) begin
        field_q <= cand;
      end
    end
  end

  assign field_o = field_q;

  // R9: update strobe restarts at the least significant field
  p_upd_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> field_q == LAST);

  // R9: no movement during hold-off
  p_holdoff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !upd_i) |=> $stable(field_q));

  // R10: only toward more significant fields
  p_widen_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> field_q <= $past(field_q));

  // keep FIELD_W referenced for width sanity
  initial begin
    a_geom_r1: assert (ACC_W >= FIELD_W + (NUM_FIELDS - 1) * FIELD_STEP);
  end
endmodule

// File: rtl/gso_scale.sv
module gso_scale #(
  parameter int ACC_W      = 32,
  parameter int FIELD_W    = 20,
  parameter int FIELD_STEP = 4,
  parameter int NUM_FIELDS = 4,
  parameter int GAIN_W     = 4,
  localparam int SEL_W     = $clog2(NUM_FIELDS),
  localparam int PROD_W    = FIELD_W + GAIN_W,
  localparam int OUT_W     = PROD_W - 2 * GAIN_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [OUT_W-1:0]  mid_o,
  output logic              ovf_o,
  output logic              neg_o
);
  localparam int TOP_W = PROD_W - (GAIN_W + OUT_W) + 1;

  logic [FIELD_W-1:0] fld [NUM_FIELDS];
  logic [FIELD_W-1:0] fsel;
  logic [PROD_W-1:0]  f_ext;
  logic [PROD_W-1:0]  g_ext;
  logic [PROD_W-1:0]  prod;
  logic [TOP_W-1:0]   top;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    assign fld[k] = acc_i[ACC_W-1-k*FIELD_STEP -: FIELD_W];
  end

  assign fsel  = fld[sel_i];
  assign f_ext = {{GAIN_W{fsel[FIELD_W-1]}}, fsel};
  assign g_ext = {{FIELD_W{1'b0}}, gain_i};
  // modular product equals the signed x unsigned result in PROD_W bits
  assign prod  = f_ext * g_ext;

  assign mid_o = prod[GAIN_W +: OUT_W];
  assign top   = prod[PROD_W-1 -: TOP_W];
  assign ovf_o = ~((&top) | ~(|top));
  assign neg_o = prod[PROD_W-1];
endmodule

// File: rtl/gso_clip.sv
module gso_clip
  import gso_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OUT_W-1:0] mid_i,
  input  logic             ovf_i,
  input  logic             neg_i,
  input  sat_mode_e        mode_i,
  input  logic [OUT_W-1:0] thr_i,
  output logic [OUT_W-1:0] data_o,
  output logic             ovf_o,
  output logic             gt_o
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] clip_d;
  logic             gt_d;

  always_comb begin
    clip_d = mid_i;
    unique case (mode_i)
      SAT_DISPLAY: begin
        if (neg_i)      clip_d = '0;
        else if (ovf_i) clip_d = POS_MAX;
      end
      SAT_SYM: begin
        if (ovf_i) clip_d = neg_i ? NEG_MAX : POS_MAX;
      end
      default: ;
    endcase
  end

  assign gt_d = $signed(clip_d) > $signed(thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ovf_o  <= 1'b0;
      gt_o   <= 1'b0;
    end else begin
      data_o <= clip_d;
      ovf_o  <= ovf_i;
      gt_o   <= gt_d;
    end
  end

  // R4: display output never negative
  p_display_nonneg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SAT_DISPLAY) |=> !data_o[OUT_W-1]);

  // R5: symmetric clamp at both rails
  p_sym_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SAT_SYM && ovf_i && !neg_i) |=> data_o == POS_MAX);
  p_sym_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SAT_SYM && ovf_i && neg_i) |=> data_o == NEG_MAX);

  // R7: flag agrees with the registered sample and last threshold
  p_gt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> gt_o == ($signed(data_o) > $signed($past(thr_i))));
endmodule

// File: rtl/gain_sat_out.sv
module gain_sat_out
  import gso_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int FIELD_W     = 20,
  parameter int FIELD_STEP  = 4,
  parameter int NUM_FIELDS  = 4,
  parameter int GAIN_W      = 4,
  parameter int FLUSH_LINES = 10,
  localparam int SEL_W      = $clog2(NUM_FIELDS),
  localparam int OUT_W      = FIELD_W - GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              hres_i,
  input  logic              upd_i,
  input  logic              auto_en_i,
  input  logic [SEL_W-1:0]  man_sel_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [1:0]        sat_mode_i,
  input  logic [OUT_W-1:0]  thr_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              ovf_o,
  output logic              gt_o,
  output logic [SEL_W-1:0]  field_o
);
  logic [SEL_W-1:0] track_sel;
  logic [SEL_W-1:0] sel;
  logic [OUT_W-1:0] mid;
  logic             ovf_c;
  logic             neg_c;
  sat_mode_e        mode;

  gso_field_track #(
    .ACC_W(ACC_W), .FIELD_W(FIELD_W), .FIELD_STEP(FIELD_STEP),
    .NUM_FIELDS(NUM_FIELDS), .FLUSH_LINES(FLUSH_LINES)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i),
    .hres_i(hres_i), .upd_i(upd_i), .field_o(track_sel)
  );

  assign sel  = auto_en_i ? track_sel : man_sel_i;
  assign mode = sat_mode_e'(sat_mode_i);

  gso_scale #(
    .ACC_W(ACC_W), .FIELD_W(FIELD_W), .FIELD_STEP(FIELD_STEP),
    .NUM_FIELDS(NUM_FIELDS), .GAIN_W(GAIN_W)
  ) u_scale (
    .acc_i(acc_i), .sel_i(sel), .gain_i(gain_i),
    .mid_o(mid), .ovf_o(ovf_c), .neg_o(neg_c)
  );

  gso_clip #(.OUT_W(OUT_W)) u_clip (
    .clk_i(clk_i), .rst_ni(rst_ni), .mid_i(mid), .ovf_i(ovf_c),
    .neg_i(neg_c), .mode_i(mode), .thr_i(thr_i),
    .data_o(data_o), .ovf_o(ovf_o), .gt_o(gt_o)
  );

  assign field_o = track_sel;

  // R11: indicator follows tracker even with manual selection
  p_indicator_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> field_o == SEL_W'(NUM_FIELDS - 1));
endmodule

// File: tb/gain_sat_out_tb_top.sv
module gain_sat_out_tb_top;
  typedef struct packed {
    logic [31:0] acc;
    logic [1:0]  sel;
    logic [3:0]  gain;
    logic [1:0]  sat;
    logic [15:0] thr;
    logic [15:0] exp_d;
    logic        exp_o;
    logic        exp_g;
  } vec_t;

  // covers R1 R2 R3 R4 R5 R6 R7
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_2340, 2'd3, 4'd1, 2'd0, 16'h1000, 16'h1234, 1'b0, 1'b1},
    '{32'h1234_5678, 2'd0, 4'd2, 2'd0, 16'h2468, 16'h2468, 1'b0, 1'b0},
    '{32'h0007_0000, 2'd3, 4'd4, 2'd0, 16'h0000, 16'hC000, 1'b1, 1'b0},
    '{32'h0007_0000, 2'd3, 4'd4, 2'd1, 16'h0000, 16'h7FFF, 1'b1, 1'b1},
    '{32'h0007_0000, 2'd3, 4'd4, 2'd2, 16'h0000, 16'h7FFF, 1'b1, 1'b1},
    '{32'hFFFF_F000, 2'd3, 4'd1, 2'd1, 16'hFFFF, 16'h0000, 1'b0, 1'b1},
    '{32'hFFFF_F000, 2'd3, 4'd1, 2'd2, 16'hFE00, 16'hFF00, 1'b0, 1'b1},
    '{32'h0008_0000, 2'd3, 4'd2, 2'd2, 16'h8000, 16'h8000, 1'b1, 1'b0},
    '{32'h0008_0000, 2'd3, 4'd2, 2'd0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{32'h0008_0000, 2'd3, 4'd2, 2'd1, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{32'h7FFF_FFFF, 2'd0, 4'd0, 2'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b1},
    '{32'h0ABC_DE00, 2'd1, 4'd1, 2'd0, 16'h0000, 16'hABCD, 1'b0, 1'b0},
    '{32'h0012_3450, 2'd2, 4'd3, 2'd0, 16'h369B, 16'h369C, 1'b0, 1'b1},
    '{32'h0007_0000, 2'd3, 4'd4, 2'd3, 16'h0000, 16'hC000, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] acc = '0;
  logic        hres = 1'b0;
  logic        upd = 1'b0;
  logic        auto_en = 1'b0;
  logic [1:0]  man_sel = '0;
  logic [3:0]  gain = '0;
  logic [1:0]  sat = '0;
  logic [15:0] thr = '0;
  logic [15:0] data;
  logic        ovf;
  logic        gt;
  logic [1:0]  field;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gain_sat_out dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .hres_i(hres), .upd_i(upd),
    .auto_en_i(auto_en), .man_sel_i(man_sel), .gain_i(gain),
    .sat_mode_i(sat), .thr_i(thr), .data_o(data), .ovf_o(ovf),
    .gt_o(gt), .field_o(field)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_hres();
    @(negedge clk) hres = 1'b1;
    @(negedge clk) hres = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R12 reset data", {16'h0, data}, 32'h0);
    check("R12 reset ovf", {31'h0, ovf}, 32'h0);
    check("R12 reset gt", {31'h0, gt}, 32'h0);
    check("R12 reset field", {30'h0, field}, 32'd3);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      acc = VECS[v].acc; man_sel = VECS[v].sel; gain = VECS[v].gain;
      sat = VECS[v].sat; thr = VECS[v].thr;
      @(negedge clk);
      check($sformatf("R1/R2/R4/R5/R6 data vec %0d", v), {16'h0, data}, {16'h0, VECS[v].exp_d});
      check($sformatf("R3 ovf vec %0d", v), {31'h0, ovf}, {31'h0, VECS[v].exp_o});
      check($sformatf("R7 gt vec %0d", v), {31'h0, gt}, {31'h0, VECS[v].exp_g});
    end
    check("R9 no move without hres", {30'h0, field}, 32'd3);

    acc = 32'h4000_0000;
    for (int i = 0; i < 9; i++) pulse_hres();
    tick(2);
    check("R9 held after nine edges", {30'h0, field}, 32'd3);
    pulse_hres();
    tick(2);
    check("R8 armed picks code 0", {30'h0, field}, 32'd0);
    acc = 32'h0;
    tick(3);
    check("R10 sticky at code 0", {30'h0, field}, 32'd0);

    upd = 1'b1;
    tick(1);
    upd = 1'b0;
    check("R9 update restarts", {30'h0, field}, 32'd3);
    acc = 32'h0010_0000;
    tick(3);
    check("R9 held after update", {30'h0, field}, 32'd3);
    acc = 32'h0;
    for (int i = 0; i < 10; i++) pulse_hres();
    tick(2);
    check("R8 small stays code 3", {30'h0, field}, 32'd3);
    acc = 32'h0010_0000;
    tick(2);
    check("R8 candidate code 2", {30'h0, field}, 32'd2);
    acc = 32'h0100_0000;
    tick(2);
    check("R8 candidate code 1", {30'h0, field}, 32'd1);
    acc = 32'h0000_1000;
    tick(2);
    check("R10 no narrowing", {30'h0, field}, 32'd1);
    acc = 32'hFFF0_0000;
    tick(2);
    check("R10 negative no narrowing", {30'h0, field}, 32'd1);

    acc = 32'h0100_0000; gain = 4'd1; sat = 2'd0; thr = 16'h0; man_sel = 2'd3;
    auto_en = 1'b1;
    tick(1);
    check("R11 auto drives datapath", {16'h0, data}, 32'h0000_1000);
    auto_en = 1'b0;
    tick(1);
    check("R11 manual code 3 data", {16'h0, data}, 32'h0);
    check("R11 indicator while manual", {30'h0, field}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule